// File: doc/BRIEF.md
# Interrupt Acknowledge CPU Interface

This block is the per-processor side of an interrupt controller. A distributor hands it a vector of pending interrupts, a priority for each, and a security attribute for each. The block applies a priority threshold and two enables: one for forwarding from the distributor and one for signalling to the processor. It then raises a request line whenever some interrupt qualifies.

The processor reads an acknowledge response to learn which interrupt to service. A valid read returns the ID of the best qualifying interrupt, marks it active and takes it out of arbitration. An end-of-interrupt write of that ID later returns it to arbitration. A read can instead return a reserved special ID and change nothing. This happens when the interface is disabled, when nothing qualifies (for example after a level source has dropped), or when the security of the read does not match the security of the winning interrupt.

The response is combinational from the current inputs. The active state changes on the clock edge at which a read or an end-of-interrupt write is presented.

Top module: `irq_cpu_iface`

## Requirements
- R1: The response word carries the interrupt ID in bits [9:0], and bits [31:10] are always zero.
- R2: Among qualifying interrupts, the one with the numerically lowest priority value wins. On equal priority, the lowest ID wins.
- R3: An interrupt qualifies only if it is pending, not active, and its priority value is strictly below the mask value. An interrupt whose priority equals the mask is not signalled.
- R4: While distributor forwarding is disabled, the request line is low and the response is 1023.
- R5: While interface signalling is disabled, the request line is low and the response is 1023.
- R6: A secure read (rd_secure_i=1) whose winner is non-secure (sec attribute 0) returns 1022 and acknowledges nothing.
- R7: A non-secure read whose winner is secure (sec attribute 1) returns 1023 and acknowledges nothing.
- R8: A read returning a real ID marks that interrupt active at that clock edge, and the interrupt stops taking part in arbitration from the next cycle.
- R9: An end-of-interrupt write with ID n clears the active mark of interrupt n at that edge. If n is still pending and qualifies, it is signalled again.
- R10: The request line is high exactly when at least one interrupt qualifies and both enables are set. The response is 1023 whenever the request line is low, including in the same cycle that a level source drops.
- R11: A read that returns 1020 or above changes no active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears all active marks |
| pend_i | input | N_SRC | Pending vector from the distributor, already gated by per-interrupt enables |
| prio_i | input | N_SRC*PRIO_W | Priority per interrupt; interrupt i occupies bits [i*PRIO_W +: PRIO_W] |
| sec_i | input | N_SRC | Security attribute per interrupt, 1 = secure |
| mask_i | input | PRIO_W | Priority threshold |
| dist_en_i | input | 1 | Distributor forwarding enable |
| cpu_en_i | input | 1 | Interface signalling enable |
| rd_en_i | input | 1 | Acknowledge read strobe |
| rd_secure_i | input | 1 | Security of the read, 1 = secure |
| eoi_we_i | input | 1 | End-of-interrupt write strobe |
| eoi_id_i | input | 10 | ID written with the end-of-interrupt |
| irq_o | output | 1 | Interrupt request to the processor |
| rd_data_o | output | 32 | Acknowledge response |

## Verification
Priority ordering is tested with several pending sets that have distinct priorities. Ties are placed at both ends of the ID range, which separates a lowest-ID tie-break from a highest-ID one. The threshold is moved onto and just past a pending priority to show whether the comparison is strict. Both enables are toggled, and the read security is crossed with secure and non-secure winners, to separate 1022 from 1023 and to show that no state moves on a refused read. Repeated acknowledges that drain the set, followed by end-of-interrupt writes, show removal from and return to arbitration. A long pseudo-random phase mixes all of these against the cycle model.

// File: rtl/irq_cpu_pkg.sv
// Package: constants shared by the CPU interface and its checker.
package irq_cpu_pkg;
    localparam int ID_W        = 10;
    localparam int RESP_W      = 32;
    localparam logic [ID_W-1:0] ID_SPURIOUS = 10'd1023;
    localparam logic [ID_W-1:0] ID_SEC_MISM = 10'd1022;
    localparam logic [ID_W-1:0] ID_RSV_BASE = 10'd1020;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic            secure;
    } winner_t;
endpackage

// File: rtl/irq_eligibility.sv
// Module: irq_eligibility
// Forms the per-interrupt qualify vector: pending, not active, and priority
// strictly below the mask. Assumes prio_i is packed PRIO_W bits per source.
module irq_eligibility #(
    parameter int N_SRC  = 224,
    parameter int PRIO_W = 8
) (
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC-1:0]        act_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]       mask_i,
    output logic [N_SRC-1:0]        elig_o
);
    // One comparator per source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign elig_o[g] = pend_i[g] && !act_i[g] && (prio_i[g*PRIO_W +: PRIO_W] < mask_i);
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Picks the qualifying source with the lowest priority value; ties go to the
// lowest index. Purely combinational linear scan. Assumes N_SRC <= 1020.
module irq_arbiter
    import irq_cpu_pkg::*;
#(
    parameter int N_SRC  = 224,
    parameter int PRIO_W = 8
) (
    input  logic [N_SRC-1:0]        elig_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [N_SRC-1:0]        sec_i,
    output winner_t                 win_o
);
    logic [PRIO_W-1:0] best_prio;

    // Scan upward; strict compare keeps the earliest index on a tie.
    always_comb begin
        win_o     = '0;
        best_prio = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!win_o.valid || prio_i[i*PRIO_W +: PRIO_W] < best_prio)) begin
                win_o.valid  = 1'b1;
                win_o.id     = ID_W'(i);
                win_o.secure = sec_i[i];
                best_prio    = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_active_track.sv
// Module: irq_active_track
// Holds one active flag per source. An acknowledge sets a flag and an
// end-of-interrupt clears one; if both hit the same flag, the set wins.
module irq_active_track
    import irq_cpu_pkg::*;
#(
    parameter int N_SRC = 224
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic [ID_W-1:0]  ack_id_i,
    input  logic             eoi_i,
    input  logic [ID_W-1:0]  eoi_id_i,
    output logic [N_SRC-1:0] act_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        // Per-source active flag update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_o[g] <= 1'b0;
            else if (ack_i && ack_id_i == ID_W'(g))
                act_o[g] <= 1'b1;
            else if (eoi_i && eoi_id_i == ID_W'(g))
                act_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_cpu_iface.sv
// Module: irq_cpu_iface (top)
// Per-processor interrupt interface: request line, acknowledge response with
// reserved special IDs, and active tracking with end-of-interrupt.
// Assumes pend_i is already gated by the distributor's per-source enables.
module irq_cpu_iface
    import irq_cpu_pkg::*;
#(
    parameter int N_SRC  = 224,
    parameter int PRIO_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic [N_SRC-1:0]        sec_i,
    input  logic [PRIO_W-1:0]       mask_i,
    input  logic                    dist_en_i,
    input  logic                    cpu_en_i,
    input  logic                    rd_en_i,
    input  logic                    rd_secure_i,
    input  logic                    eoi_we_i,
    input  logic [ID_W-1:0]         eoi_id_i,
    output logic                    irq_o,
    output logic [RESP_W-1:0]       rd_data_o
);
    logic [N_SRC-1:0] act_q;
    logic [N_SRC-1:0] elig;
    winner_t          win;
    logic [ID_W-1:0]  resp_id;
    logic             ack_fire;

    irq_eligibility #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_elig (
        .pend_i (pend_i),
        .act_i  (act_q),
        .prio_i (prio_i),
        .mask_i (mask_i),
        .elig_o (elig)
    );

    irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
        .elig_i (elig),
        .prio_i (prio_i),
        .sec_i  (sec_i),
        .win_o  (win)
    );

    // Request line: same test the acknowledge response is built on.
    assign irq_o = dist_en_i && cpu_en_i && win.valid;

    // Response selection, including the refused-read special IDs.
    always_comb begin
        ack_fire = 1'b0;
        if (!irq_o)
            resp_id = ID_SPURIOUS;
        else if (win.secure && !rd_secure_i)
            resp_id = ID_SPURIOUS;
        else if (!win.secure && rd_secure_i)
            resp_id = ID_SEC_MISM;
        else begin
            resp_id  = win.id;
            ack_fire = rd_en_i;
        end
    end

    assign rd_data_o = {{(RESP_W-ID_W){1'b0}}, resp_id};

    irq_active_track #(.N_SRC(N_SRC)) i_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_i    (ack_fire),
        .ack_id_i (resp_id),
        .eoi_i    (eoi_we_i),
        .eoi_id_i (eoi_id_i),
        .act_o    (act_q)
    );
endmodule

// File: rtl/irq_cpu_iface_chk.sv
// Module: irq_cpu_iface_chk
// Property checker for irq_cpu_iface, attached by bind below.
module irq_cpu_iface_chk
    import irq_cpu_pkg::*;
#(
    parameter int N_SRC  = 224,
    parameter int PRIO_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]       mask_i,
    input logic                    dist_en_i,
    input logic                    cpu_en_i,
    input logic                    rd_en_i,
    input logic                    eoi_we_i,
    input logic                    irq_o,
    input logic [RESP_W-1:0]       rd_data_o,
    input logic [N_SRC-1:0]        act_q
);
    localparam logic [RESP_W-1:0] NSRC_W = RESP_W'(N_SRC);

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[RESP_W-1:ID_W] == '0);

    a_r4_dist_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en_i |-> (!irq_o && rd_data_o == RESP_W'(ID_SPURIOUS)));

    a_r5_cpu_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_en_i |-> (!irq_o && rd_data_o == RESP_W'(ID_SPURIOUS)));

    a_r3_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o < NSRC_W) |-> (prio_i[rd_data_o[ID_W-1:0]*PRIO_W +: PRIO_W] < mask_i));

    a_r10_no_req_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> rd_data_o == RESP_W'(ID_SPURIOUS));

    a_r8_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_data_o < NSRC_W) |=> act_q[$past(rd_data_o[ID_W-1:0])]);

    a_r11_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !eoi_we_i && rd_data_o >= RESP_W'(ID_RSV_BASE)) |=> $stable(act_q));
endmodule

bind irq_cpu_iface irq_cpu_iface_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_chk (.*);

// File: tb/test_irq_cpu_iface.sv
// Bench: behavioural cycle model of the interface, compared on every clock.
module test_irq_cpu_iface;
    localparam int N      = 224;
    localparam int PW     = 8;
    localparam int CLK_P  = 10;
    localparam int WDOG   = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    pend_i = '0;
    logic [N*PW-1:0] prio_i = '0;
    logic [N-1:0]    sec_i = '0;
    logic [PW-1:0]   mask_i = '0;
    logic dist_en_i = 1'b0, cpu_en_i = 1'b0, rd_en_i = 1'b0, rd_secure_i = 1'b0, eoi_we_i = 1'b0;
    logic [9:0]      eoi_id_i = '0;
    logic            irq_o;
    logic [31:0]     rd_data_o;

    irq_cpu_iface #(.N_SRC(N), .PRIO_W(PW)) i_irq_cpu_iface (.*);

    always #(CLK_P/2) clk = ~clk;

    // Model state.
    bit m_pend[N];
    bit m_sec[N];
    bit m_act[N];
    int m_prio[N];
    int m_mask;
    bit m_dist, m_cpu, m_rd, m_rds, m_eoi;
    int m_eoi_id;
    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R11";
    int cyc = 0;

    function automatic int best_src();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && !m_act[i] && m_prio[i] < m_mask)
                if (b < 0 || m_prio[i] < m_prio[b]) b = i;
        return b;
    endfunction

    function automatic bit m_irq();
        return m_dist && m_cpu && best_src() >= 0;
    endfunction

    function automatic int m_resp();
        int b = best_src();
        if (!m_irq()) return 1023;
        if (m_sec[b] && !m_rds) return 1023;
        if (!m_sec[b] && m_rds) return 1022;
        return b;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Drive DUT from the model inputs.
    task automatic apply();
        for (int i = 0; i < N; i++) begin
            pend_i[i] = m_pend[i];
            sec_i[i]  = m_sec[i];
            prio_i[i*PW +: PW] = PW'(m_prio[i]);
        end
        mask_i = PW'(m_mask);
        dist_en_i = m_dist; cpu_en_i = m_cpu;
        rd_en_i = m_rd; rd_secure_i = m_rds;
        eoi_we_i = m_eoi; eoi_id_i = 10'(m_eoi_id);
    endtask

    // One clock: apply, compare before the edge, advance model at the edge.
    task automatic cycle();
        int r;
        apply();
        #3;
        r = m_resp();
        check(cur_req, int'(irq_o), int'(m_irq()));
        check(cur_req, int'(rd_data_o[9:0]), r);
        check("R1", int'(rd_data_o[31:10]), 0);
        @(posedge clk);
        cyc++;
        if (m_eoi && m_eoi_id < N) m_act[m_eoi_id] = 1'b0;
        if (m_rd && r < N) m_act[r] = 1'b1;
        @(negedge clk);
        m_rd = 0; m_eoi = 0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_sec[i] = 0; m_prio[i] = 200;
        end
    endtask

    task automatic read(bit s);
        m_rd = 1; m_rds = s; cycle();
    endtask

    task automatic eoi(int id);
        m_eoi = 1; m_eoi_id = id; cycle();
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_all();
        for (int i = 0; i < N; i++) m_act[i] = 0;
        m_mask = 255; m_dist = 1; m_cpu = 1; m_rd = 0; m_rds = 0; m_eoi = 0; m_eoi_id = 0;
        apply();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state, nothing pending: R11 read refused, no change.
        cur_req = "R11";
        cycle();
        read(0);
        read(1);

        // R2: distinct priorities; R8: drain by acknowledges.
        cur_req = "R2";
        m_pend[5] = 1; m_prio[5] = 40;
        m_pend[100] = 1; m_prio[100] = 10;
        m_pend[223] = 1; m_prio[223] = 20;
        m_pend[0] = 1; m_prio[0] = 90;
        cycle();
        cur_req = "R8";
        repeat (5) read(0);
        cycle();
        // R9: return to arbitration.
        cur_req = "R9";
        eoi(223);
        cycle();
        eoi(100);
        read(0);
        eoi(100); eoi(223); eoi(5); eoi(0);
        cycle();

        // R2 tie on equal priority at both ends.
        cur_req = "R2";
        clear_all();
        m_pend[223] = 1; m_prio[223] = 7;
        m_pend[3] = 1; m_prio[3] = 7;
        m_pend[0] = 1; m_prio[0] = 7;
        cycle();
        read(0); read(0); read(0);
        eoi(0); eoi(3); eoi(223);

        // R3: mask boundary.
        cur_req = "R3";
        clear_all();
        m_pend[50] = 1; m_prio[50] = 30;
        m_mask = 30; cycle();
        m_mask = 31; cycle();
        m_mask = 0;  cycle();
        m_mask = 255;

        // R4 / R5 enables.
        cur_req = "R4";
        m_dist = 0; cycle(); read(0);
        m_dist = 1;
        cur_req = "R5";
        m_cpu = 0; cycle(); read(0);
        m_cpu = 1; cycle();

        // R6 / R7 security mismatch, no state change.
        cur_req = "R6";
        read(1); read(1);
        cur_req = "R7";
        m_sec[50] = 1;
        read(0); read(0);
        read(1);
        eoi(50);
        cur_req = "R6";
        m_sec[50] = 0;
        read(0); eoi(50);

        // R10: level source drops, request falls same cycle.
        cur_req = "R10";
        m_pend[50] = 1; cycle();
        m_pend[50] = 0; read(0);
        cycle();

        // Mixed pseudo-random phase.
        cur_req = "R10";
        for (int k = 0; k < 400; k++) begin
            for (int j = 0; j < 6; j++) begin
                int s = $urandom_range(N-1);
                m_pend[s] = $urandom_range(1);
                m_prio[s] = $urandom_range(15);
                m_sec[s] = $urandom_range(1);
            end
            m_mask = $urandom_range(16);
            m_dist = ($urandom_range(9) != 0);
            m_cpu  = ($urandom_range(9) != 0);
            m_rd   = $urandom_range(1);
            m_rds  = $urandom_range(1);
            m_eoi  = ($urandom_range(2) == 0);
            m_eoi_id = $urandom_range(N-1);
            cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule